// File: doc/BRIEF.md
# Serial Display-Register Write Parser

This block sits behind a byte-level serial slave (SPI or I2C) and turns the received byte stream into write strobes for a 15-row by 30-column display register array. The array has two planes: one holds 9-bit character indices and the other holds attributes. The top bits of each byte mark it as a row address, a column address or data. The parser tracks three packet formats. Format a repeats row, column and data. Format b repeats column and data inside the current row. Format c is a bulk run of data bytes with automatic address increment.

The same block serves the I2C read path. After a read slave address it presents a 10-byte measurement block one byte at a time, and after that a fixed dummy value. It does not cover bit-level shifting, the register RAM or the measurement logic. The front end supplies bytes with a valid flag, plus one-cycle start and stop indications. For SPI these come from chip-select going low and going high.

Top module: `serial_wr_parser`

## Requirements
- R1: After reset, and outside a packet (before any start, or after a stop), bytes produce no write strobe and `rd_active` is low.
- R2: Where an address is expected, a byte with bit7=1 is a row byte: bits 4..0 give the row and bit5 selects the plane (0 = character index, 1 = attribute). A row byte never produces a strobe.
- R3: Where an address is expected, a byte with bit7=0 is a column byte: bits 4..0 give the column, bit6=1 selects format c and bit6=0 selects format a/b. Bit5 becomes bit 8 of the written value on the character plane. On the attribute plane, bit 8 is always written as 0.
- R4: Each data byte yields exactly one `wr_en` pulse in the following clock cycle. It carries `wr_addr` = row*30+column, the plane, and the 9-bit value {bit8, byte}.
- R5: In format a/b, the byte after a data byte is again decoded as an address. A column byte alone reuses the latched row and plane (format b).
- R6: In format c, every byte is data. The address advances by one after each byte: the column wraps from 29 to 0 and the row then increments. Bit 8 stays at the value taken from the column byte.
- R7: Once in format c, a byte with bit7=1 is written as data and does not change the format until the packet ends.
- R8: After row 14, column 29, the format c address returns to 0 when `WRAP_END`=1, and stays at 449 when `WRAP_END`=0.
- R9: With `i2c_mode`=1, the first byte after a start is the slave address. 7Ah opens a write packet, 7Bh opens a read packet, and any other value makes the parser ignore bytes until the next start.
- R10: In a read packet, `rd_active` is high and `tx_byte` shows measurement byte k (bits 8k+7..8k of `meas_bus`) after k `tx_req` pulses, for k = 0..9. After that it shows 8'hFF.
- R11: A stop ends the packet. A new start always begins in the address/slave stage, even from format c.
- R12: With `i2c_mode`=0, the first byte after a start is decoded directly as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2c_mode | input | 1 | 1: the first byte of a packet is an I2C slave address |
| pkt_start | input | 1 | One-cycle start of packet |
| pkt_stop | input | 1 | One-cycle end of packet |
| byte_vld | input | 1 | Received byte valid |
| byte_in | input | 8 | Received byte |
| tx_req | input | 1 | Front end has taken the current read byte |
| meas_bus | input | 80 | Measurement block, byte k at bits 8k+7..8k |
| tx_byte | output | 8 | Byte to transmit on the read path |
| rd_active | output | 1 | Read packet in progress |
| wr_en | output | 1 | One-cycle write strobe |
| wr_plane | output | 1 | 0 = character index plane, 1 = attribute plane |
| wr_addr | output | 9 | Word address row*30+column |
| wr_data | output | 9 | Value written |

## Verification
The bound checker checks these rules on every cycle:
- a strobe only follows a data byte in a data state;
- address bytes never strobe;
- the attribute plane never receives bit 8 set;
- format c is left only by a start or a stop;
- an idle parser stays quiet;
- the read byte holds between requests.

The exact decoded addresses, the sticky bit 8 across a bulk run, the row carry, the wrap or saturate choice at the end of the array, the slave-address filter and the order of the measurement bytes can only be seen in the bench's directed and random packets. The bench compares those against its own address model.

// File: rtl/serial_wr_parser.sv
module serial_wr_parser #(
  parameter int ROWS       = 15,
  parameter int COLS       = 30,
  parameter bit WRAP_END   = 1'b1,
  parameter logic [6:0] SLAVE_ID = 7'h3D,
  parameter int MEAS_BYTES = 10,
  parameter logic [7:0] DUMMY = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i2c_mode,
  input  logic                    pkt_start,
  input  logic                    pkt_stop,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  input  logic                    tx_req,
  input  logic [8*MEAS_BYTES-1:0] meas_bus,
  output logic [7:0]              tx_byte,
  output logic                    rd_active,
  output logic                    wr_en,
  output logic                    wr_plane,
  output logic [$clog2(ROWS*COLS)-1:0] wr_addr,
  output logic [8:0]              wr_data
);
  localparam int AW = $clog2(ROWS*COLS);
  localparam int IW = $clog2(MEAS_BYTES+1);
  localparam logic [4:0] LAST_ROW = 5'(ROWS-1);
  localparam logic [4:0] LAST_COL = 5'(COLS-1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_SLV = 3'd1, S_ADDR = 3'd2,
    S_DAB = 3'd3, S_DC = 3'd4, S_READ = 3'd5
  } st_t;

  st_t st;
  logic [4:0] row, col;
  logic plane, d8;
  logic [IW-1:0] rd_idx;

  assign rd_active = (st == S_READ);
  assign tx_byte = (rd_idx < IW'(MEAS_BYTES)) ? meas_bus[8*int'(rd_idx) +: 8] : DUMMY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      row <= '0;
      col <= '0;
      plane <= 1'b0;
      d8 <= 1'b0;
      rd_idx <= '0;
      wr_en <= 1'b0;
      wr_plane <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (pkt_start) begin
        st <= i2c_mode ? S_SLV : S_ADDR;
        rd_idx <= '0;
      end else if (pkt_stop) begin
        st <= S_IDLE;
      end else begin
        if (st == S_READ && tx_req && rd_idx != IW'(MEAS_BYTES))
          rd_idx <= rd_idx + 1'b1;
        if (byte_vld) begin
          case (st)
            S_SLV: begin
              if (byte_in[7:1] != SLAVE_ID) st <= S_IDLE;
              else st <= byte_in[0] ? S_READ : S_ADDR;
            end
            S_ADDR: begin
              if (byte_in[7]) begin
                plane <= byte_in[5];
                row <= byte_in[4:0];
              end else begin
                col <= byte_in[4:0];
                d8 <= byte_in[5];
                st <= byte_in[6] ? S_DC : S_DAB;
              end
            end
            S_DAB, S_DC: begin
              wr_en <= 1'b1;
              wr_plane <= plane;
              wr_addr <= AW'(row * COLS + col);
              wr_data <= {d8 & ~plane, byte_in};
              if (st == S_DAB) begin
                st <= S_ADDR;
              end else if (col != LAST_COL) begin
                col <= col + 1'b1;
              end else if (row != LAST_ROW) begin
                col <= '0;
                row <= row + 1'b1;
              end else if (WRAP_END) begin
                col <= '0;
                row <= '0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serial_wr_parser_chk.sv
module serial_wr_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       pkt_start,
  input logic       pkt_stop,
  input logic       tx_req,
  input logic       wr_en,
  input logic       wr_plane,
  input logic [8:0] wr_data,
  input logic [7:0] tx_byte,
  input logic [2:0] st
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ADDR = 3'd2, C_DAB = 3'd3, C_DC = 3'd4, C_READ = 3'd5;

  p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_vld) && ($past(st) == C_DAB || $past(st) == C_DC)));

  p_addr_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && st == C_ADDR && !pkt_start && !pkt_stop) |=> !wr_en);

  p_attr_d8_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_plane) |-> !wr_data[8]);

  p_bulk_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DC && !pkt_start && !pkt_stop) |=> st == C_DC);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && !pkt_start) |=> (st == C_IDLE && !wr_en));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_READ && !tx_req && !pkt_start && !pkt_stop) |=> $stable(tx_byte));
endmodule

bind serial_wr_parser serial_wr_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .pkt_start(pkt_start),
  .pkt_stop(pkt_stop), .tx_req(tx_req), .wr_en(wr_en), .wr_plane(wr_plane),
  .wr_data(wr_data), .tx_byte(tx_byte), .st(st)
);

// File: tb/serial_wr_parser_test.sv
module serial_wr_parser_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, i2c_mode = 1'b0, pkt_start = 1'b0, pkt_stop = 1'b0;
  logic byte_vld = 1'b0, tx_req = 1'b0;
  logic [7:0] byte_in = '0;
  logic [79:0] meas_bus = '0;
  logic [7:0] tx_byte, tx_byte_s;
  logic rd_active, rd_active_s, wr_en, wr_en_s, wr_plane, wr_plane_s;
  logic [8:0] wr_addr, wr_addr_s, wr_data, wr_data_s;

  serial_wr_parser uut (.clk, .rst_n, .i2c_mode, .pkt_start, .pkt_stop, .byte_vld, .byte_in,
    .tx_req, .meas_bus, .tx_byte, .rd_active, .wr_en, .wr_plane, .wr_addr, .wr_data);

  serial_wr_parser #(.WRAP_END(1'b0)) uut_sat (.clk, .rst_n, .i2c_mode, .pkt_start, .pkt_stop,
    .byte_vld, .byte_in, .tx_req, .meas_bus, .tx_byte(tx_byte_s), .rd_active(rd_active_s),
    .wr_en(wr_en_s), .wr_plane(wr_plane_s), .wr_addr(wr_addr_s), .wr_data(wr_data_s));

  int n_chk = 0, n_fail = 0;
  logic [18:0] lg [0:4095];
  logic [18:0] lg_s [0:4095];
  logic [18:0] ex [0:4095];
  int nlog = 0, nlog_s = 0, nex = 0;

  always @(negedge clk) if (rst_n) begin
    if (wr_en && nlog < 4096) begin lg[nlog] = {wr_data, wr_plane, wr_addr}; nlog++; end
    if (wr_en_s && nlog_s < 4096) begin lg_s[nlog_s] = {wr_data_s, wr_plane_s, wr_addr_s}; nlog_s++; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic clear; nlog = 0; nlog_s = 0; nex = 0; endtask

  task automatic expw(int addr, bit plane, logic [8:0] data);
    ex[nex] = {data, plane, 9'(addr)}; nex++;
  endtask

  task automatic send(logic [7:0] b);
    byte_vld = 1'b1; byte_in = b; @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic start_pkt(bit i2c);
    i2c_mode = i2c; pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
  endtask

  task automatic stop_pkt;
    pkt_stop = 1'b1; @(negedge clk); pkt_stop = 1'b0; @(negedge clk);
  endtask

  task automatic compare(string tag);
    chk({tag, " write count"}, nlog, nex);
    for (int i = 0; i < nex && i < nlog; i++) chk(tag, 32'(lg[i]), 32'(ex[i]));
  endtask

  function automatic int nxt(int pos);
    return (pos == 449) ? 0 : pos + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 10; k++) meas_bus[8*k +: 8] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and bytes outside a packet
    chk("R1 wr_en after reset", wr_en, 0);
    chk("R1 rd_active after reset", rd_active, 0);
    clear();
    send(8'h81); send(8'h05); send(8'h55); @(negedge clk);
    compare("R1 no packet");

    // R2 R3 R4 R5 format a, both planes
    clear();
    start_pkt(0);
    send(8'h83); send(8'h25); send(8'hA5); expw(3*30+5, 0, 9'h1A5);
    send(8'hA2); send(8'h27); send(8'h3C); expw(2*30+7, 1, 9'h03C);
    // R5 format b reuses row 2 attribute plane
    send(8'h0A); send(8'h11); expw(2*30+10, 1, 9'h011);
    send(8'h21); send(8'hF0); expw(2*30+1, 1, 9'h0F0);
    stop_pkt();
    compare("R2 R3 R4 R5 format a/b");

    // R6 R7 format c with sticky D8 and bit7 data
    clear();
    start_pkt(0);
    send(8'h81); send(8'h7C);
    send(8'h10); expw(58, 0, 9'h110);
    send(8'h11); expw(59, 0, 9'h111);
    send(8'h12); expw(60, 0, 9'h112);
    send(8'h93); expw(61, 0, 9'h193);
    send(8'h85); expw(62, 0, 9'h185);
    stop_pkt();
    compare("R6 R7 format c");

    // R8 end of array: wrap versus saturate
    clear();
    start_pkt(0);
    send(8'h8E); send(8'h5C);
    send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    stop_pkt();
    expw(448, 0, 9'h001); expw(449, 0, 9'h002); expw(0, 0, 9'h003); expw(1, 0, 9'h004);
    compare("R8 wrap");
    chk("R8 saturate count", nlog_s, 4);
    chk("R8 saturate 2", 32'(lg_s[2]), {13'h0, 1'b0, 9'd449} | (32'h003 << 10));
    chk("R8 saturate 3", 32'(lg_s[3]), {13'h0, 1'b0, 9'd449} | (32'h004 << 10));

    // R11 stop ends packet, start leaves format c
    clear();
    start_pkt(0);
    send(8'h81); send(8'h42); send(8'h01); expw(32, 0, 9'h001);
    stop_pkt();
    send(8'h33); send(8'h44); @(negedge clk);
    start_pkt(0);
    send(8'h84); send(8'h03); send(8'h77); expw(123, 0, 9'h077);
    stop_pkt();
    compare("R11 stop and restart");

    // R12 SPI first byte is an address byte
    clear();
    start_pkt(0);
    send(8'h86); send(8'h04); send(8'h55); expw(184, 0, 9'h055);
    stop_pkt();
    compare("R12 spi first byte");

    // R9 I2C write address accepted, other address rejected
    clear();
    start_pkt(1);
    send(8'h7A); send(8'h85); send(8'h01); send(8'h44); expw(151, 0, 9'h044);
    stop_pkt();
    start_pkt(1);
    send(8'h70); send(8'h85); send(8'h01); send(8'h44);
    stop_pkt();
    compare("R9 slave address");

    // R10 I2C read sequence
    start_pkt(1);
    send(8'h7B);
    chk("R10 rd_active", rd_active, 1);
    for (int k = 0; k < 13; k++) begin
      chk($sformatf("R10 read byte %0d", k), tx_byte, (k < 10) ? 32'(meas_bus[8*k +: 8]) : 32'hFF);
      tx_req = 1'b1; @(negedge clk); tx_req = 1'b0; @(negedge clk);
    end
    stop_pkt();
    chk("R1 rd_active after stop", rd_active, 0);

    // R4 R6 random packets
    for (int it = 0; it < 60; it++) begin
      bit i2c = 1'($urandom);
      bit plane = 1'($urandom);
      bit d8 = 1'($urandom);
      int r = $urandom_range(0, 14);
      int c = $urandom_range(0, 29);
      int pos;
      logic [7:0] b;
      clear();
      start_pkt(i2c);
      if (i2c) send(8'h7A);
      send({1'b1, 1'b0, plane, 5'(r)});
      if ($urandom_range(0, 1) == 1) begin
        int n = $urandom_range(1, 40);
        send({1'b0, 1'b1, d8, 5'(c)});
        pos = r*30 + c;
        for (int j = 0; j < n; j++) begin
          b = 8'($urandom);
          send(b);
          expw(pos, plane, {d8 & ~plane, b});
          pos = nxt(pos);
        end
        stop_pkt();
        compare("R6 random format c");
      end else begin
        int n = $urandom_range(1, 6);
        for (int j = 0; j < n; j++) begin
          c = $urandom_range(0, 29);
          d8 = 1'($urandom);
          b = 8'($urandom);
          send({1'b0, 1'b0, d8, 5'(c)});
          send(b);
          expw(r*30 + c, plane, {d8 & ~plane, b});
        end
        stop_pkt();
        compare("R4 random format a/b");
      end
    end

    summary();
    $finish;
  end
endmodule